// File: doc/BRIEF.md
# Bidirectional I/O Port with Transmit-Pin Takeover

This block is an eight-bit general-purpose I/O port sitting on a small memory-mapped register bus. Software writes an output latch and a per-pin direction mask. Each pin's output enable follows its mask bit, and the pin is always presented with its latch value. A read of the data address returns, bit by bit, either the latch or the pin level, with the direction bit making the choice. Pin levels pass through one register stage before they reach the read path.

Pin 0 can be handed to a serial transmitter. While the transmitter's enable input is high, pin 0 is driven by the transmitter's data line and its output buffer is on, whatever its direction bit holds. The direction bit of pin 0 still chooses what a data read returns for that bit. When the enable drops, pin 0 is an ordinary port pin again.

The bus has a chip select, a write enable, a four-bit address, write data and combinational read data. A write takes effect at the clock edge at which it is presented. Read data is valid in the same cycle as the select.

Top module: `pio_port`

## Requirements
- R1: Asynchronous active-low reset clears the latch to 0x00 and the direction register to 0x00. With the serial enable low, every output enable is then 0 and a read of the direction address (0xC) returns 0x00.
- R2: A selected write to address 0x8 loads the latch at that clock edge, whatever the direction bits are. pin_out bits 7..1 always equal the latch, and so does bit 0 while the serial enable is low.
- R3: A selected write to address 0xC loads the direction register. A read of 0xC returns exactly the value written. pin_oe[i] equals direction bit i for every pin not under serial control.
- R4: A read of address 0x8 returns, for each bit i, latch bit i when direction bit i is 1, and otherwise the level of pin_in[i] sampled at the previous clock edge.
- R5: Reads of any address other than 0x8 and 0xC return 0x00, and so does any cycle without a select. Writes to other addresses change neither the latch nor the direction register.
- R6: While ser_en is 1, pin_oe[0] is 1 and pin_out[0] equals ser_tx, whatever the value of direction bit 0.
- R7: While ser_en is 1, bit 0 of a read of 0x8 is still chosen by direction bit 0: the latch bit when it is 1, the sampled pin level when it is 0.
- R8: While ser_en is 0, pin_oe[0] follows direction bit 0 and pin_out[0] follows latch bit 0.
- R9: If the latch is written before a direction bit goes from 0 to 1, the pin shows the new latch value in the first cycle its output enable is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Bus chip select |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Register address |
| wdata | input | W | Write data |
| rdata | output | W | Read data, combinational |
| pin_in | input | W | Levels seen at the pads |
| pin_out | output | W | Values presented to the pad drivers |
| pin_oe | output | W | Per-pin output enables |
| ser_en | input | 1 | Serial transmitter takes pin 0 when high |
| ser_tx | input | 1 | Serial transmitter data for pin 0 |

## Verification
The bench uses the default parameters: a width of eight, with the latch at 0x8 and the direction register at 0xC. At this width, direction masks such as 0xF0 and 0xFE split the read path into a latch half and a pin half within one byte. Bit 0 can then take the serial override while the other seven bits still check that the latch and mask are undisturbed. The fixed addresses also leave unmapped addresses such as 0x4 available for the ignored-access checks.

// File: rtl/pio_port.sv
module pio_port #(
  parameter int W = 8,
  parameter logic [3:0] DATA_ADDR = 4'h8,
  parameter logic [3:0] DIR_ADDR  = 4'hC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         wr_en,
  input  logic [3:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  input  logic         ser_en,
  input  logic         ser_tx
);
  logic [W-1:0] lat_q, dir_q, pin_q;

  wire wr_dat = sel && wr_en && (addr == DATA_ADDR);
  wire wr_dir = sel && wr_en && (addr == DIR_ADDR);
  wire rd     = sel && !wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_dat) lat_q <= wdata;
      if (wr_dir) dir_q <= wdata;
    end
  end

  always_ff @(posedge clk) pin_q <= pin_in;

  assign pin_oe  = dir_q | {{(W-1){1'b0}}, ser_en};
  assign pin_out = {lat_q[W-1:1], ser_en ? ser_tx : lat_q[0]};

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (addr == DATA_ADDR)     rdata = (dir_q & lat_q) | (~dir_q & pin_q);
      else if (addr == DIR_ADDR) rdata = dir_q;
    end
  end
endmodule

module pio_port_chk #(
  parameter int W = 8,
  parameter logic [3:0] DATA_ADDR = 4'h8,
  parameter logic [3:0] DIR_ADDR  = 4'hC
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sel,
  input logic         wr_en,
  input logic [3:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] rdata,
  input logic [W-1:0] pin_in,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic         ser_en,
  input logic         ser_tx,
  input logic [W-1:0] lat_q,
  input logic [W-1:0] dir_q
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (lat_q == '0) && (dir_q == '0));

  assert_latch_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && addr == DATA_ADDR) |=> (lat_q == $past(wdata)));

  assert_dir_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && addr == DIR_ADDR) |=> (dir_q == $past(wdata)));

  assert_read_mux_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr_en && addr == DATA_ADDR) |->
      (rdata == ((dir_q & lat_q) | (~dir_q & $past(pin_in)))));

  assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel || (!wr_en && addr != DATA_ADDR && addr != DIR_ADDR)) |-> (rdata == '0));

  assert_unmapped_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sel && wr_en && (addr == DATA_ADDR || addr == DIR_ADDR))) |=>
      ($stable(lat_q) && $stable(dir_q)));

  assert_override_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> (pin_oe[0] && pin_out[0] == ser_tx));

  assert_plain_pin0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |-> (pin_oe[0] == dir_q[0] && pin_out[0] == lat_q[0]));

  assert_upper_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe[W-1:1] == dir_q[W-1:1]) && (pin_out[W-1:1] == lat_q[W-1:1]));
endmodule

bind pio_port pio_port_chk #(.W(W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)) u_chk (.*);

// File: tb/test_pio_port.sv
module test_pio_port;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       sel = 0, wr_en = 0, ser_en = 0, ser_tx = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, pin_in = 0;
  logic [7:0] rdata, pin_out, pin_oe;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  int         kind_q[$];
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  pio_port i_pio_port (.clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .addr(addr),
                       .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
                       .pin_oe(pin_oe), .ser_en(ser_en), .ser_tx(ser_tx));

  task automatic drive(input logic s, input logic w, input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    sel = s; wr_en = w; addr = a; wdata = d;
  endtask

  task automatic idle(); drive(0, 0, 4'h0, 8'h00); endtask

  task automatic expect_item(input int k, input logic [7:0] e, input string t);
    kind_q.push_back(k); exp_q.push_back(e); tag_q.push_back(t);
  endtask

  always @(negedge clk) begin
    while (kind_q.size() > 0) begin
      automatic int         k = kind_q.pop_front();
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string      t = tag_q.pop_front();
      automatic logic [7:0] a = (k == 0) ? rdata : (k == 1) ? pin_out : pin_oe;
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: %s actual %02h expected %02h", t,
                 (k == 0) ? "rdata" : (k == 1) ? "pin_out" : "pin_oe", a, e);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    idle();
    expect_item(2, 8'h00, "R1 oe");
    expect_item(1, 8'h00, "R1 out");
    drive(1, 0, 4'hC, 0); expect_item(0, 8'h00, "R1 dir read");
    drive(1, 0, 4'h8, 0); expect_item(0, 8'h00, "R1 data read");
    // R2 latch written while all pins are inputs
    drive(1, 1, 4'h8, 8'hA5);
    idle(); pin_in = 8'h3C;
    expect_item(1, 8'hA5, "R2 out follows latch");
    expect_item(2, 8'h00, "R2 oe still off");
    drive(1, 0, 4'h8, 0); expect_item(0, 8'h3C, "R4 read pins when dir 0");
    // R3 direction mask
    drive(1, 1, 4'hC, 8'hF0);
    drive(1, 0, 4'hC, 0);
    expect_item(0, 8'hF0, "R3 dir readback");
    expect_item(2, 8'hF0, "R3 oe follows dir");
    drive(1, 0, 4'h8, 0); expect_item(0, 8'hAC, "R4 mixed mask");
    // R4 pin sampled one clock earlier
    drive(1, 0, 4'h8, 0); pin_in = 8'h5A;
    expect_item(0, 8'hAC, "R4 old sample same cycle");
    drive(1, 0, 4'h8, 0); expect_item(0, 8'hAA, "R4 new sample next cycle");
    // R5 unmapped access
    drive(1, 0, 4'h4, 0); expect_item(0, 8'h00, "R5 unmapped read");
    drive(0, 0, 4'hC, 0); expect_item(0, 8'h00, "R5 no select");
    drive(1, 1, 4'h4, 8'hFF);
    drive(1, 0, 4'hC, 0);
    expect_item(0, 8'hF0, "R5 dir untouched");
    expect_item(1, 8'hA5, "R5 latch untouched");
    // R9 latch before direction
    drive(1, 1, 4'h8, 8'h0F);
    drive(1, 1, 4'hC, 8'hFF);
    expect_item(1, 8'h0F, "R9 latch ready before enable");
    idle();
    expect_item(2, 8'hFF, "R9 enabled");
    expect_item(1, 8'h0F, "R9 first enabled value");
    // R6 / R7 serial takeover
    drive(1, 1, 4'hC, 8'hFE);
    idle(); ser_en = 1; ser_tx = 0; pin_in = 8'h00;
    expect_item(2, 8'hFF, "R6 oe forced");
    expect_item(1, 8'h0E, "R6 tx drives pin0");
    drive(1, 0, 4'h8, 0); expect_item(0, 8'h0E, "R7 bit0 from pin when dir0=0");
    idle(); ser_tx = 1;
    expect_item(1, 8'h0F, "R6 tx high");
    drive(1, 1, 4'hC, 8'hFF); ser_tx = 0;
    drive(1, 0, 4'h8, 0);
    expect_item(0, 8'h0F, "R7 bit0 from latch when dir0=1");
    expect_item(1, 8'h0E, "R6 tx overrides latch");
    // R8 release of pin 0
    drive(1, 1, 4'hC, 8'hFE);
    idle(); ser_en = 0;
    expect_item(2, 8'hFE, "R8 oe follows dir");
    expect_item(1, 8'h0F, "R8 out follows latch");
    idle(); ser_en = 1;
    expect_item(2, 8'hFF, "R6 toggle on");
    idle(); ser_en = 0;
    expect_item(2, 8'hFE, "R8 toggle off");
    // R1 reset in the middle of a sequence
    drive(1, 1, 4'h8, 8'h77);
    drive(1, 1, 4'hC, 8'h33);
    idle(); rst_n = 0;
    idle();
    idle(); rst_n = 1;
    expect_item(2, 8'h00, "R1 oe after mid reset");
    expect_item(1, 8'h00, "R1 out after mid reset");
    drive(1, 0, 4'hC, 0); expect_item(0, 8'h00, "R1 dir after mid reset");
    idle();
    idle();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule